// File: doc/BRIEF.md
# Serial-to-Parallel Time-Slot Switch

This block moves 8-bit channels from a set of serial input streams onto one byte-wide parallel output, in any order. Every stream carries a fixed number of channels per frame, sent MSB first. The block turns each channel into a byte and stores it in a data memory with two banks. One bank fills during the current frame while the other, which holds the complete previous frame, is read. A single frame pulse aligns both the serial side and the parallel side.

The parallel side runs a fixed number of output slots per frame. Each slot has a 16-bit connection word. The low byte and bit 8 form the source address in the data memory. The upper bits hold the slot's driver enable, a bypass select and a control field that drives side-band outputs. With bypass set, the slot takes the parallel input byte presented during the same slot instead of serial data.

A host writes connection words into a staging copy through an address, data and byte-select port. The staging copy moves into the active copy at every frame pulse, so a frame never sees a word change part-way through.

Top module: `ser2par_tsi`

## Requirements
- R1: Stream `st` carries channel `ch` as 8 bits, MSB first, in frame cycles `8*ch` to `8*ch+7`. Frame cycle 0 is the cycle in which `frame_i` is high. The byte is stored at data-memory address `st*CH_PER_STREAM + ch`, which with the defaults is `32*st + ch`, covering addresses 0 to 511.
- R2: In frame F, a switched slot outputs the byte stored during frame F-1 at the source address. The source address is `{word[8], word[7:0]}`.
- R3: Slot `s` is looked up in frame cycle `s+1` and appears on the outputs during frame cycle `s+2`. Outside these output cycles, `pdo_oe_o`, `pdo_o` and `ctrl_o` are all zero.
- R4: When enable bit `word[15]` is clear, the slot drives `pdo_oe_o` = 0 and `pdo_o` = 0. When the bit is set, `pdo_oe_o` = 1.
- R5: When `word[15]` and bypass bit `word[14]` are both set, the slot outputs the `pdi_i` value sampled in frame cycle `s+1` of the same frame.
- R6: `ctrl_o` carries `word[13:9]` during the slot's output cycle, whatever the state of the enable bit.
- R7: One source address may feed any number of slots in the same frame.
- R8: A host write with `cm_be_i[0]` set updates `word[7:0]`. A host write with `cm_be_i[1]` set updates `word[15:8]`. A byte whose select bit is clear keeps its old value.
- R9: A host write takes effect from the next `frame_i` pulse. A frame already in progress keeps the old word for every slot. A write made in the same cycle as the pulse takes effect at the pulse after that.
- R10: Reset clears every connection word. After reset, every slot is disabled and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one serial bit per stream per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame start pulse, marks frame cycle 0 |
| ser_i | input | NUM_STREAMS | Serial input streams, MSB first |
| pdi_i | input | 8 | Parallel input byte used by bypass slots |
| cm_we_i | input | 1 | Host connection-word write strobe |
| cm_addr_i | input | SLOT_W | Slot number for the host write |
| cm_wdata_i | input | 16 | Connection word to write |
| cm_be_i | input | 2 | Byte selects for the write: bit 0 = low byte, bit 1 = high byte |
| pdo_o | output | 8 | Parallel output byte |
| pdo_oe_o | output | 1 | Output driver enable for the current slot |
| ctrl_o | output | 5 | Per-slot control outputs |

## Verification
The hardest case to reach from the ports is a host write that lands while a frame's slots are being output. Its effect should show up only one frame later, and a bench that only compares steady-state frames cannot see the difference. The stimulus waits for a fixed early frame cycle, rewrites a slot that has not yet been output in that frame, and checks that the slot still shows the old word in that frame and the new one in the next. Expected values come from a staging model that the bench copies into an active snapshot at every frame pulse. Serial data patterns depend on the frame number, so any read from the wrong bank shows up as a data mismatch.

// File: rtl/ser2par_tsi_pkg.sv
`timescale 1ns/1ps
package ser2par_tsi_pkg;
  localparam int SRC_W  = 9;
  localparam int CTRL_W = 5;
  localparam int CM_W   = 16;

  typedef struct packed {
    logic              en;
    logic              byp;
    logic [CTRL_W-1:0] ctrl;
    logic              addr_hi;
  } cm_hi_t;

  typedef struct packed {
    cm_hi_t     hi;
    logic [7:0] lo;
  } cm_word_t;
endpackage

// File: rtl/s2p_frame_ctr.sv
`timescale 1ns/1ps
module s2p_frame_ctr #(
  parameter int FRAME_BITS = 256,
  parameter int NUM_SLOTS  = 16,
  parameter int FB_W       = $clog2(FRAME_BITS),
  parameter int SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  output logic [FB_W-1:0]   bit_idx_o,
  output logic              bank_o,
  output logic              slot_act_o,
  output logic [SLOT_W-1:0] slot_idx_o
);
  logic [FB_W-1:0] cnt_q, cur;
  logic            bank_q;

  assign cur = frame_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      cnt_q <= (cur == FB_W'(FRAME_BITS - 1)) ? '0 : cur + FB_W'(1);
      if (frame_i) bank_q <= ~bank_q;
    end
  end

  assign bit_idx_o  = cur;
  assign bank_o     = bank_q;
  // slot s is looked up one cycle after its frame index, once banks have swapped
  assign slot_act_o = (cur != '0) && (cur <= FB_W'(NUM_SLOTS));
  assign slot_idx_o = SLOT_W'(cur - FB_W'(1));

  // R3
  frame_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (cnt_q == FB_W'(1)));
endmodule

// File: rtl/s2p_deser_mem.sv
`timescale 1ns/1ps
module s2p_deser_mem #(
  parameter int NUM_STREAMS   = 16,
  parameter int CH_PER_STREAM = 32,
  parameter int CH_W          = $clog2(CH_PER_STREAM),
  parameter int FB_W          = CH_W + 3,
  parameter int DM_AW         = $clog2(NUM_STREAMS * CH_PER_STREAM)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_STREAMS-1:0] ser_i,
  input  logic [FB_W-1:0]        bit_idx_i,
  input  logic                   wr_bank_i,
  input  logic                   rd_bank_i,
  input  logic [DM_AW-1:0]       rd_addr_i,
  output logic [7:0]             rd_data_o
);
  localparam int ST_W = DM_AW - CH_W;

  logic [NUM_STREAMS-1:0][7:0] rd_byte;
  logic [CH_W-1:0]             rd_ch;
  logic [ST_W-1:0]             rd_st;
  logic                        byte_done;
  logic [CH_W-1:0]             wr_ch;

  assign rd_ch     = rd_addr_i[CH_W-1:0];
  assign rd_st     = rd_addr_i[DM_AW-1:CH_W];
  assign byte_done = (bit_idx_i[2:0] == 3'd7);
  assign wr_ch     = bit_idx_i[FB_W-1:3];

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_stream
    logic [6:0] shift_q;
    logic [7:0] byte_w;
    logic [7:0] mem_q [2][CH_PER_STREAM];

    assign byte_w = {shift_q, ser_i[g]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) shift_q <= '0;
      else         shift_q <= byte_w[6:0];
    end

    always_ff @(posedge clk_i) begin
      if (byte_done) mem_q[wr_bank_i][wr_ch] <= byte_w;
    end

    assign rd_byte[g] = mem_q[rd_bank_i][rd_ch];
  end

  assign rd_data_o = rd_byte[rd_st];
endmodule

// File: rtl/s2p_conn_mem.sv
`timescale 1ns/1ps
module s2p_conn_mem
  import ser2par_tsi_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              we_i,
  input  logic [SLOT_W-1:0] addr_i,
  input  logic [CM_W-1:0]   wdata_i,
  input  logic [1:0]        be_i,
  input  logic [SLOT_W-1:0] rd_idx_i,
  output cm_word_t          rd_word_o
);
  logic [NUM_SLOTS-1:0][CM_W-1:0] stage_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (we_i && addr_i == SLOT_W'(i)) begin
          if (be_i[0]) stage_q[i][7:0]  <= wdata_i[7:0];
          if (be_i[1]) stage_q[i][15:8] <= wdata_i[15:8];
        end
        // staged word (pre-write value) becomes live at the frame pulse
        if (frame_i) act_q[i] <= stage_q[i];
      end
    end
  end

  assign rd_word_o = cm_word_t'(act_q[rd_idx_i]);

  // R9
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(act_q));
endmodule

// File: rtl/s2p_out_stage.sv
`timescale 1ns/1ps
module s2p_out_stage
  import ser2par_tsi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              act_i,
  input  logic              en_i,
  input  logic              byp_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [7:0]        sw_data_i,
  input  logic [7:0]        pdi_i,
  output logic [7:0]        pdo_o,
  output logic              oe_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdo_o  <= '0;
      oe_o   <= 1'b0;
      ctrl_o <= '0;
    end else if (act_i) begin
      oe_o   <= en_i;
      pdo_o  <= !en_i ? 8'h00 : (byp_i ? pdi_i : sw_data_i);
      ctrl_o <= ctrl_i;
    end else begin
      oe_o   <= 1'b0;
      pdo_o  <= '0;
      ctrl_o <= '0;
    end
  end

  // R4
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (pdo_o == 8'h00));

  // R5
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && en_i && byp_i) |=> (oe_o && pdo_o == $past(pdi_i)));
endmodule

// File: rtl/ser2par_tsi.sv
`timescale 1ns/1ps
module ser2par_tsi
  import ser2par_tsi_pkg::*;
#(
  parameter int NUM_STREAMS   = 16,
  parameter int CH_PER_STREAM = 32,
  parameter int NUM_SLOTS     = 16,
  parameter int SLOT_W        = $clog2(NUM_SLOTS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_i,
  input  logic [NUM_STREAMS-1:0] ser_i,
  input  logic [7:0]             pdi_i,
  input  logic                   cm_we_i,
  input  logic [SLOT_W-1:0]      cm_addr_i,
  input  logic [15:0]            cm_wdata_i,
  input  logic [1:0]             cm_be_i,
  output logic [7:0]             pdo_o,
  output logic                   pdo_oe_o,
  output logic [4:0]             ctrl_o
);
  localparam int CH_W       = $clog2(CH_PER_STREAM);
  localparam int FRAME_BITS = CH_PER_STREAM * 8;
  localparam int FB_W       = $clog2(FRAME_BITS);
  localparam int DM_AW      = $clog2(NUM_STREAMS * CH_PER_STREAM);

  logic [FB_W-1:0]   bit_idx;
  logic              bank;
  logic              slot_act;
  logic [SLOT_W-1:0] slot_idx;
  cm_word_t          word;
  logic [SRC_W-1:0]  src;
  logic [7:0]        sw_data;

  s2p_frame_ctr #(
    .FRAME_BITS (FRAME_BITS),
    .NUM_SLOTS  (NUM_SLOTS),
    .FB_W       (FB_W),
    .SLOT_W     (SLOT_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .bit_idx_o  (bit_idx),
    .bank_o     (bank),
    .slot_act_o (slot_act),
    .slot_idx_o (slot_idx)
  );

  s2p_deser_mem #(
    .NUM_STREAMS   (NUM_STREAMS),
    .CH_PER_STREAM (CH_PER_STREAM),
    .CH_W          (CH_W),
    .FB_W          (FB_W),
    .DM_AW         (DM_AW)
  ) u_dmem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ser_i     (ser_i),
    .bit_idx_i (bit_idx),
    .wr_bank_i (bank),
    .rd_bank_i (~bank),
    .rd_addr_i (DM_AW'(src)),
    .rd_data_o (sw_data)
  );

  s2p_conn_mem #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_cmem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .we_i      (cm_we_i),
    .addr_i    (cm_addr_i),
    .wdata_i   (cm_wdata_i),
    .be_i      (cm_be_i),
    .rd_idx_i  (slot_idx),
    .rd_word_o (word)
  );

  assign src = {word.hi.addr_hi, word.lo};

  s2p_out_stage u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (slot_act),
    .en_i      (word.hi.en),
    .byp_i     (word.hi.byp),
    .ctrl_i    (word.hi.ctrl),
    .sw_data_i (sw_data),
    .pdi_i     (pdi_i),
    .pdo_o     (pdo_o),
    .oe_o      (pdo_oe_o),
    .ctrl_o    (ctrl_o)
  );

  // R3
  oe_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdo_oe_o |-> $past(slot_act));
endmodule

// File: tb/ser2par_tsi_tb.sv
`timescale 1ns/1ps
module ser2par_tsi_tb;
  localparam int NS = 16, CH = 32, NSL = 16, SW = 4, FB = CH * 8;

  logic          clk_i = 1'b0, rst_ni = 1'b0, frame_i = 1'b0;
  logic [NS-1:0] ser_i = '0;
  logic [7:0]    pdi_i = '0;
  logic          cm_we_i = 1'b0;
  logic [SW-1:0] cm_addr_i = '0;
  logic [15:0]   cm_wdata_i = '0;
  logic [1:0]    cm_be_i = '0;
  logic [7:0]    pdo_o;
  logic          pdo_oe_o;
  logic [4:0]    ctrl_o;

  int errors = 0, checks = 0;
  int bc = 0, fr = 0, done_cnt = 0, cap_fr = 0;
  logic started = 1'b0;
  logic [15:0] host_cm [NSL];
  logic [15:0] act_snap [NSL];
  logic [7:0]  cap_d [NSL];
  logic        cap_oe [NSL];
  logic [4:0]  cap_ctrl [NSL];
  logic        idle_oe;
  logic [7:0]  idle_d;

  ser2par_tsi u_dut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] ser_pat(int f, int st, int ch);
    return 8'(f * 29 + st * 11 + ch * 7 + 5);
  endfunction

  function automatic logic [7:0] pdi_pat(int f, int s);
    return 8'(f * 13 + s * 19 + 165);
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // frame driver and output monitor in one process
  initial begin
    wait (started);
    forever begin
      @(negedge clk_i);
      if (bc >= 2 && bc <= NSL + 1) begin
        cap_d[bc-2]    = pdo_o;
        cap_oe[bc-2]   = pdo_oe_o;
        cap_ctrl[bc-2] = ctrl_o;
      end
      if (bc == NSL + 4) begin
        idle_oe = pdo_oe_o;
        idle_d  = pdo_o;
      end
      if (bc == NSL + 5) begin
        cap_fr = fr;
        done_cnt++;
      end
      if (bc == 0) for (int i = 0; i < NSL; i++) act_snap[i] = host_cm[i];
      frame_i = (bc == 0);
      for (int st = 0; st < NS; st++) begin
        logic [7:0] b;
        b = ser_pat(fr, st, bc / 8);
        ser_i[st] = b[7 - (bc % 8)];
      end
      pdi_i = pdi_pat(fr, bc - 1);
      bc++;
      if (bc == FB) begin
        bc = 0;
        fr++;
      end
    end
  end

  task automatic host_write(int slot, logic [15:0] data, logic [1:0] be);
    while (bc < 4 || bc > FB - 4) @(negedge clk_i);
    cm_we_i    = 1'b1;
    cm_addr_i  = SW'(slot);
    cm_wdata_i = data;
    cm_be_i    = be;
    if (be[0]) host_cm[slot][7:0]  = data[7:0];
    if (be[1]) host_cm[slot][15:8] = data[15:8];
    @(negedge clk_i);
    cm_we_i = 1'b0;
    cm_be_i = '0;
  endtask

  task automatic check_frame(string req);
    int t;
    t = done_cnt;
    wait (done_cnt != t);
    for (int s = 0; s < NSL; s++) begin
      logic [15:0] w;
      logic [7:0]  ed;
      int          src;
      w   = act_snap[s];
      src = int'(w[8:0]);
      ed  = !w[15] ? 8'h00 : (w[14] ? pdi_pat(cap_fr, s) : ser_pat(cap_fr - 1, src / CH, src % CH));
      check(cap_oe[s] == w[15] && cap_d[s] == ed && cap_ctrl[s] == w[13:9], req,
            $sformatf("frame %0d slot %0d {oe,ctrl,data}", cap_fr, s),
            int'({cap_oe[s], cap_ctrl[s], cap_d[s]}), int'({w[15], w[13:9], ed}));
    end
    // R3 idle cycles after the slot window
    check(idle_oe == 1'b0 && idle_d == 8'h00, "R3", "idle cycle {oe,data}",
          int'({idle_oe, idle_d}), 0);
  endtask

  task automatic test_reset();
    check(pdo_oe_o == 1'b0 && pdo_o == 8'h00 && ctrl_o == 5'd0, "R10", "outputs in reset",
          int'({pdo_oe_o, ctrl_o, pdo_o}), 0);
    @(negedge clk_i);
    rst_ni  = 1'b1;
    started = 1'b1;
    repeat (5) @(negedge clk_i);
    check(pdo_oe_o == 1'b0 && pdo_o == 8'h00, "R10", "outputs after reset",
          int'({pdo_oe_o, pdo_o}), 0);
    check_frame("R10");
  endtask

  task automatic test_identity();
    for (int s = 0; s < NSL; s++) host_write(s, 16'h8000 | 16'(s), 2'b11);
    check_frame("R2");
    check_frame("R1");
  endtask

  task automatic test_spread();
    for (int s = 0; s < NSL; s++) begin
      int a;
      a = (15 - s) * CH + ((s * 7 + 3) % CH);
      if (s == 0) a = 511;
      if (s == 1) a = 256;
      host_write(s, 16'h8000 | 16'(a), 2'b11);
    end
    check_frame("R1");
    check_frame("R2");
  endtask

  task automatic test_multicast();
    for (int s = 0; s < NSL; s++)
      host_write(s, (s % 2 == 0) ? 16'h8000 | 16'd77 : 16'h0000 | 16'd77, 2'b11);
    check_frame("R7");
    check_frame("R4");
    check(cap_d[0] == cap_d[2] && cap_d[2] == cap_d[14] && cap_oe[14], "R7",
          "shared source bytes", int'(cap_d[14]), int'(cap_d[0]));
    check(cap_oe[3] == 1'b0 && cap_d[3] == 8'h00, "R4", "disabled slot 3",
          int'({cap_oe[3], cap_d[3]}), 0);
  endtask

  task automatic test_bypass();
    for (int s = 0; s < NSL; s++) begin
      logic [15:0] w;
      w = {1'b0, 1'b1, 5'(s + 3), 9'(s * 5 + 40)};
      if (s % 3 == 0) w[15] = 1'b1;
      if (s % 3 == 2) begin w[15] = 1'b1; w[14] = 1'b0; end
      host_write(s, w, 2'b11);
    end
    check_frame("R5");
    check_frame("R6");
    check(cap_oe[1] == 1'b0 && cap_ctrl[1] == 5'd4, "R6", "ctrl on disabled slot 1",
          int'({cap_oe[1], cap_ctrl[1]}), 4);
    check(cap_d[3] == pdi_pat(cap_fr, 3), "R5", "bypass slot 3",
          int'(cap_d[3]), int'(pdi_pat(cap_fr, 3)));
  endtask

  task automatic test_byte_select();
    for (int s = 0; s < 4; s++) host_write(s, 16'h8030, 2'b11);
    check_frame("R8");
    host_write(0, 16'h4A07, 2'b01);
    host_write(1, 16'h81FF, 2'b10);
    check_frame("R8");
    check_frame("R8");
    check(cap_oe[0] && cap_d[0] == ser_pat(cap_fr - 1, 0, 7), "R8", "low-byte-only slot 0",
          int'(cap_d[0]), int'(ser_pat(cap_fr - 1, 0, 7)));
    check(cap_d[1] == ser_pat(cap_fr - 1, 9, 16), "R8", "high-byte-only slot 1",
          int'(cap_d[1]), int'(ser_pat(cap_fr - 1, 9, 16)));
  endtask

  task automatic test_midframe();
    host_write(12, 16'h8000 | 16'd5, 2'b11);
    check_frame("R9");
    check_frame("R9");
    while (bc != 2) @(negedge clk_i);
    host_write(12, 16'h0005, 2'b11);
    check_frame("R9");
    check(cap_oe[12] == 1'b1, "R9", "old word kept in current frame", int'(cap_oe[12]), 1);
    check_frame("R9");
    check(cap_oe[12] == 1'b0, "R9", "new word at next frame", int'(cap_oe[12]), 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSL; i++) begin
      host_cm[i]  = '0;
      act_snap[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    test_reset();
    test_identity();
    test_spread();
    test_multicast();
    test_bypass();
    test_byte_select();
    test_midframe();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule